// File: doc/BRIEF.md
# Polled Serial Configuration Port Controller

This block is a serial master that sets up external memory devices over a three-wire link: a serial clock, a command line and a bidirectional data line. The data line is exposed as separate output, output-enable and input pins so that the pad ring can build the tri-state buffer. Software controls the block through two registers, a command register and a data register, on a simple write port with a combinational read-back.

A transaction starts only when the command register is written. The block then shifts the command code out on the command line. For a write it then drives the data register contents on the data line. For a read it leaves the data line undriven and collects the device's response into the data register. The block has no command queue. A busy bit in the command register tells software when it may issue the next command. A command written while busy is dropped and recorded in a sticky overrun bit. To write, software polls until busy is clear, loads the data register, and then writes the command register.

Top module: `scfg_master`

## Requirements
- R1: After reset both registers read as zero (busy, overrun, read flag, command code and data all 0), and the serial clock, command line and data output-enable are low.
- R2: Register address 0 is the command register and address 1 is the data register. A write to address 0 while busy is 0 starts a frame, and busy (command register bit REG_W-1) reads 1 from the next clock on.
- R3: The serial clock idles low and toggles every DIV/2 system clocks while a frame runs. The first rising edge comes DIV/2 clocks after the accepting edge, and each frame has exactly CMD_W+DATA_W rising edges.
- R4: The command code, bits [CMD_W-1:0] of the command write, goes out on the command line most significant bit first, one bit per serial clock period. Each bit changes only at a falling serial clock edge or at frame start.
- R5: In a write frame (command write bit CMD_W = 0), the DATA_W data bits follow the command on the data line, most significant bit first, with output-enable high for exactly those bits. Output-enable is never high during the command bits.
- R6: In a read frame (command write bit CMD_W = 1), output-enable stays low for the whole frame. The data line is sampled at the rising serial clock edge of each data bit, and the DATA_W samples replace the data register, first sample in the most significant bit.
- R7: Busy clears exactly (CMD_W+DATA_W)·DIV+1 system clocks after the accepting edge, which is one clock after the final falling serial clock edge. In a read frame the captured data is readable in that same cycle.
- R8: A command write while busy is 1 leaves the running frame and the command register fields unchanged. It sets the overrun bit (command register bit REG_W-2), which then stays set until reset. This includes a write in the final busy cycle.
- R9: A data register write while busy is 1 is ignored.
- R10: The command register reads back the command code in [CMD_W-1:0] and the read flag in bit CMD_W of the last accepted command, with overrun and busy in their bits. The data register reads back in [DATA_W-1:0]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Read-back of the selected register |
| sclk | output | 1 | Serial clock |
| scmd | output | 1 | Serial command line |
| sdata_o | output | 1 | Data line value when driven |
| sdata_oe | output | 1 | Data line output enable |
| sdata_i | input | 1 | Data line value from the pad |

## Verification
Completion of a read frame and rejection of a late command write can fall on the same edge: the tail cycle, where busy still reads 1, is also the cycle in which the captured response is moved into the data register. The bench provokes this by writing the command register exactly in the last busy cycle of a read frame. It then checks that the overrun bit is set, that the command fields still show the finished command, and that the data register holds the device response. A separate mid-frame collision also tries a data write and checks that the outgoing frame and the stored data are unaffected.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    typedef enum logic {
        REG_CMD  = 1'b0,
        REG_DATA = 1'b1
    } scfg_reg_e;

endpackage

// File: rtl/scfg_clkgen.sv
module scfg_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          sclk;
        logic [CW-1:0] cnt;
    } cg_t;

    cg_t cg_d, cg_q;
    logic wrap;

    assign wrap = run && (cg_q.cnt == CW'(HALF - 1));

    always_comb begin
        cg_d = cg_q;
        if (!run) begin
            cg_d.cnt  = '0;
            cg_d.sclk = 1'b0;
        end else if (wrap) begin
            cg_d.cnt  = '0;
            cg_d.sclk = ~cg_q.sclk;
        end else begin
            cg_d.cnt = cg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

    assign sclk_o = cg_q.sclk;
    assign rise_o = wrap && !cg_q.sclk;
    assign fall_o = wrap &&  cg_q.sclk;

    // R3: the serial clock returns low whenever the frame is not running
    assert_sclk_parks_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk_o);

endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [CMD_W+DATA_W-1:0] load_vec,
    input  logic                  shift,
    input  logic                  capture,
    input  logic                  sdi,
    output logic                  msb,
    output logic                  last_bit,
    output logic                  data_phase,
    output logic [DATA_W-1:0]     rx
);
    localparam int N  = CMD_W + DATA_W;
    localparam int BW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]      shreg;
        logic [DATA_W-1:0] rx;
        logic [BW-1:0]     bitc;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.shreg = load_vec;
            sh_d.bitc  = '0;
            sh_d.rx    = '0;
        end else begin
            if (shift) begin
                sh_d.shreg = {sh_q.shreg[N-2:0], 1'b0};
                sh_d.bitc  = sh_q.bitc + 1'b1;
            end
            if (capture) begin
                sh_d.rx = {sh_q.rx[DATA_W-2:0], sdi};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb        = sh_q.shreg[N-1];
    assign last_bit   = (sh_q.bitc == BW'(N - 1));
    assign data_phase = (sh_q.bitc >= BW'(CMD_W));
    assign rx         = sh_q.rx;

    // R4: the bit position leaves the data field only through a new load
    assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_phase) |-> $past(load));

    // R3: never more bit positions than a frame holds
    assert_bit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last_bit);

endmodule

// File: rtl/scfg_master.sv
module scfg_master
    import scfg_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16,
    parameter int DIV    = 4,
    parameter int REG_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sclk,
    output logic             scmd,
    output logic             sdata_o,
    output logic             sdata_oe,
    input  logic             sdata_i
);
    localparam int N        = CMD_W + DATA_W;
    localparam int BUSY_BIT = REG_W - 1;
    localparam int OVR_BIT  = REG_W - 2;
    localparam int USED_W   = (DATA_W > CMD_W + 1) ? DATA_W : CMD_W + 1;

    typedef struct packed {
        logic              busy;
        logic              tail;
        logic              ovr;
        logic              rd;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] dat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic cmd_wr, dat_wr, accept, run;
    logic rise, fall, last_bit, data_phase, msb;
    logic load, shift, capture;
    logic [DATA_W-1:0] rx;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata[REG_W-1:USED_W];

    assign cmd_wr  = reg_wr && (reg_addr == REG_CMD);
    assign dat_wr  = reg_wr && (reg_addr == REG_DATA);
    assign accept  = cmd_wr && !ctl_q.busy;
    assign run     = ctl_q.busy && !ctl_q.tail;
    assign load    = accept;
    assign shift   = fall && !last_bit;
    assign capture = rise && data_phase && ctl_q.rd;

    scfg_clkgen #(.DIV(DIV)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sclk_o (sclk),
        .rise_o (rise),
        .fall_o (fall)
    );

    scfg_shifter #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_vec   ({reg_wdata[CMD_W-1:0], ctl_q.dat}),
        .shift      (shift),
        .capture    (capture),
        .sdi        (sdata_i),
        .msb        (msb),
        .last_bit   (last_bit),
        .data_phase (data_phase),
        .rx         (rx)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cmd_wr) begin
            if (ctl_q.busy) begin
                ctl_d.ovr = 1'b1;
            end else begin
                ctl_d.busy = 1'b1;
                ctl_d.rd   = reg_wdata[CMD_W];
                ctl_d.cmd  = reg_wdata[CMD_W-1:0];
            end
        end
        if (dat_wr && !ctl_q.busy) begin
            ctl_d.dat = reg_wdata[DATA_W-1:0];
        end
        if (run && fall && last_bit) begin
            ctl_d.tail = 1'b1;
        end
        if (ctl_q.tail) begin
            ctl_d.tail = 1'b0;
            ctl_d.busy = 1'b0;
            if (ctl_q.rd) ctl_d.dat = rx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_CMD) begin
            reg_rdata[CMD_W-1:0] = ctl_q.cmd;
            reg_rdata[CMD_W]     = ctl_q.rd;
            reg_rdata[OVR_BIT]   = ctl_q.ovr;
            reg_rdata[BUSY_BIT]  = ctl_q.busy;
        end else begin
            reg_rdata[DATA_W-1:0] = ctl_q.dat;
        end
    end

    assign scmd     = run && !data_phase && msb;
    assign sdata_oe = run && data_phase && !ctl_q.rd;
    assign sdata_o  = sdata_oe && msb;

    // R2: an accepted command raises busy on the next clock
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !ctl_q.busy) |=> ctl_q.busy);

    // R8: a colliding command is flagged and does not disturb the fields
    assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && ctl_q.busy) |=> (ctl_q.ovr && $stable(ctl_q.cmd) && $stable(ctl_q.rd)));

    // R8: overrun is sticky
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ovr |=> ctl_q.ovr);

    // R7: busy only drops out of the tail cycle, with the serial clock low
    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.busy) |-> ($past(ctl_q.tail) && !sclk));

    // R9: data writes during a frame leave the data register alone
    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && ctl_q.busy && !ctl_q.tail) |=> $stable(ctl_q.dat));

    // R1: the serial clock is idle whenever no frame is in progress
    assert_idle_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.busy |-> !sclk);

endmodule

// File: tb/scfg_master_bench.sv
module scfg_master_bench;
    localparam int CMD_W  = 8;
    localparam int DATA_W = 16;
    localparam int DIV    = 4;
    localparam int REG_W  = 32;
    localparam int N      = CMD_W + DATA_W;
    localparam int HALF   = DIV / 2;
    localparam int FRAME  = N * DIV + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             sclk, scmd, sdata_o, sdata_oe;
    logic             sdata_i = 1'b0;

    int checks = 0;
    int fails  = 0;

    // device model state
    int                dev_pos = 0;
    int                dev_neg = 0;
    logic [CMD_W-1:0]  dev_cmd = '0;
    logic [DATA_W-1:0] dev_dat = '0;
    logic [DATA_W-1:0] dev_resp = '0;
    logic              dev_rd = 1'b0;
    logic              oe_bad = 1'b0;

    always #5 clk = ~clk;

    scfg_master #(.CMD_W(CMD_W), .DATA_W(DATA_W), .DIV(DIV), .REG_W(REG_W)) u_scfg_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sclk      (sclk),
        .scmd      (scmd),
        .sdata_o   (sdata_o),
        .sdata_oe  (sdata_oe),
        .sdata_i   (sdata_i)
    );

    always @(posedge sclk) begin
        if (dev_pos < CMD_W) begin
            dev_cmd = {dev_cmd[CMD_W-2:0], scmd};
            if (sdata_oe) oe_bad = 1'b1;
        end else begin
            dev_dat = {dev_dat[DATA_W-2:0], sdata_o};
            if (dev_rd == sdata_oe) oe_bad = 1'b1;
        end
        dev_pos = dev_pos + 1;
    end

    always @(negedge sclk) begin
        dev_neg = dev_neg + 1;
        if (dev_neg >= CMD_W && dev_neg < N)
            sdata_i = dev_resp[DATA_W-1-(dev_neg-CMD_W)];
    end

    function automatic logic [REG_W-1:0] exp_cmd_reg(input logic busy, input logic ovr,
                                                     input logic rd, input logic [CMD_W-1:0] c);
        logic [REG_W-1:0] v;
        v = '0;
        v[CMD_W-1:0] = c;
        v[CMD_W]     = rd;
        v[REG_W-2]   = ovr;
        v[REG_W-1]   = busy;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [REG_W-1:0] act,
                         input logic [REG_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [REG_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // inject_at: busy cycle in which a colliding command write is made (0 = none)
    task automatic do_xfer(input logic rd, input logic [CMD_W-1:0] c,
                           input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] resp,
                           input int inject_at, input logic ovr_before);
        logic [REG_W-1:0] r;
        logic [DATA_W-1:0] exp_d;
        int busy_cycles;
        int first_hi;
        int hi;
        int guard;
        bit done;
        guard = 0;
        done = 1'b0;
        while (!done) begin
            reg_read(1'b0, r);
            if (!r[REG_W-1] || guard > 1000) done = 1'b1;
            else begin
                guard++;
                @(negedge clk);
            end
        end
        dev_pos = 0;
        dev_neg = 0;
        dev_cmd = '0;
        dev_dat = '0;
        dev_resp = resp;
        dev_rd = rd;
        oe_bad = 1'b0;
        sdata_i = 1'b0;
        if (!rd) bus_write(1'b1, REG_W'(d));
        exp_d = rd ? resp : d;
        if (!rd) exp_d = d;
        else begin
            reg_read(1'b1, r);
            exp_d = resp;
        end
        bus_write(1'b0, exp_cmd_reg(1'b0, 1'b0, rd, c));
        reg_read(1'b0, r);
        check(r[REG_W-1] == 1'b1, "R2 busy after command write", r, exp_cmd_reg(1'b1, ovr_before, rd, c));
        busy_cycles = 0;
        first_hi = 0;
        hi = 0;
        done = 1'b0;
        while (!done) begin
            reg_read(1'b0, r);
            if (!r[REG_W-1] || busy_cycles > 4 * FRAME) done = 1'b1;
            else begin
                busy_cycles++;
                if (sclk) begin
                    hi++;
                    if (first_hi == 0) first_hi = busy_cycles;
                end
                if (inject_at != 0 && busy_cycles == inject_at) begin
                    reg_wr = 1'b1;
                    reg_addr = 1'b0;
                    reg_wdata = exp_cmd_reg(1'b0, 1'b0, ~rd, ~c);
                end
                if (inject_at != 0 && inject_at + 2 < FRAME && busy_cycles == inject_at + 2) begin
                    reg_wr = 1'b1;
                    reg_addr = 1'b1;
                    reg_wdata = REG_W'(~d);
                end
                @(negedge clk);
                reg_wr = 1'b0;
                reg_addr = 1'b0;
            end
        end
        check(busy_cycles == FRAME, "R7 busy length", REG_W'(busy_cycles), REG_W'(FRAME));
        check(first_hi == HALF + 1, "R3 first rising edge", REG_W'(first_hi), REG_W'(HALF + 1));
        check(hi == N * HALF, "R3 high cycles per frame", REG_W'(hi), REG_W'(N * HALF));
        check(dev_pos == N, "R3 rising edges per frame", REG_W'(dev_pos), REG_W'(N));
        check(dev_cmd == c, "R4 command bits", REG_W'(dev_cmd), REG_W'(c));
        if (!rd) begin
            check(dev_dat == d, "R5 write data bits", REG_W'(dev_dat), REG_W'(d));
            check(!oe_bad, "R5 output enable window", REG_W'(oe_bad), '0);
        end else begin
            check(!oe_bad, "R6 data line released on read", REG_W'(oe_bad), '0);
        end
        reg_read(1'b1, r);
        check(r == REG_W'(exp_d), rd ? "R6 read data loaded" : "R9 data register kept", r, REG_W'(exp_d));
        reg_read(1'b0, r);
        check(r == exp_cmd_reg(1'b0, ovr_before || (inject_at != 0), rd, c),
              inject_at != 0 ? "R8 overrun and fields kept" : "R10 command readback",
              r, exp_cmd_reg(1'b0, ovr_before || (inject_at != 0), rd, c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [REG_W-1:0] r;
        int unsigned seed_val;
        seed_val = $urandom(32'd20240611);
        do_reset();
        reg_read(1'b0, r);
        check(r == '0, "R1 command register reset", r, '0);
        reg_read(1'b1, r);
        check(r == '0, "R1 data register reset", r, '0);
        check(!sclk && !scmd && !sdata_oe, "R1 idle pins", {29'd0, sclk, scmd, sdata_oe}, '0);

        // directed corners
        do_xfer(1'b0, 8'hFF, 16'hFFFF, 16'h0000, 0, 1'b0);
        do_xfer(1'b0, 8'h80, 16'h0001, 16'h0000, 0, 1'b0);
        do_xfer(1'b1, 8'h01, 16'h0000, 16'h8001, 0, 1'b0);
        do_xfer(1'b1, 8'h5A, 16'hFFFF, 16'h0000, 0, 1'b0);

        // constrained random frames
        for (int i = 0; i < 16; i++) begin
            do_xfer(1'($urandom()), CMD_W'($urandom()), DATA_W'($urandom()),
                    DATA_W'($urandom()), 0, 1'b0);
        end

        // R8 collision in the final busy cycle of a read frame
        do_xfer(1'b1, 8'hC3, 16'h0000, 16'hA5F0, FRAME, 1'b0);

        do_reset();
        reg_read(1'b0, r);
        check(r == '0, "R1 overrun cleared by reset", r, '0);

        // R8 and R9 collision in the middle of a write frame
        do_xfer(1'b0, 8'h3C, 16'h1234, 16'h0000, 10, 1'b0);
        do_xfer(1'b0, 8'h99, 16'h4321, 16'h0000, 0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule